// File: doc/BRIEF.md
# Adaptive Cubic Line Interpolator

This block upsamples a single line of 8-bit pixels by a programmable ratio. Pixels arrive on a valid/ready stream with a flag on the last pixel of each line. A phase accumulator steps through the line. Each output pixel is interpolated between two centre samples from a window of four neighbours. The interpolation uses a cubic kernel written in difference form. Before each output is computed, the window is sorted into one of three curve classes by comparing its two slope estimates, and the outer-tap weights are chosen from that class.

The same block serves a horizontal pass (pixels along a row) and a vertical pass (one column of line-memory outputs). It is reconfigured for each pass through the step and threshold inputs. Those inputs must stay constant while a line is in flight. Outputs come out on a valid-only stream with no backpressure, one pixel at a time in order of position.

Top module: `acs_scaler`

## Requirements
- R1: While reset is held and right after it is released, out_valid is 0 and in_ready is 1.
- R2: For window samples p0..p3 and phase s = ph/256, the output is p1 + w·(p0−p2)·A(s) + w·(p1−p3)·B(s) + (p1−p2)·C(s). Here A(s)=s(1−s)², B(s)=s²(s−1) and C(s)=s²(2s−3). In the smooth class w = −1/2, so a linear ramp is reproduced exactly.
- R3: Output j of a line sits at position j·step/256. Its window index is the integer part and its phase is the low 8 bits. A line of N ≥ 2 pixels yields exactly the positions below N−1, i.e. ceil((N−1)·256/step) outputs. The phase restarts at 0 on every line.
- R4: Beyond the first three pixels of a line, a pixel is accepted only in the cycle where the phase addition carries out of 8 bits. With step 64 and an input that is always valid, successive accepts are 4 cycles apart.
- R5: With d1 = p2−p0 and d2 = p3−p1, a window with d1−d2 above the threshold uses w = −3/4 (concave class), and one with d2−d1 above the threshold uses w = −1/4 (convex class).
- R6: Missing neighbours at the ends of a line are filled by replicating the first pixel (left) and the last pixel (right).
- R7: The weighted sum is rounded to nearest with halves rounded up, then clamped to 0..255.
- R8: An output appears 4 clock edges after the cycle it is issued. For a line presented back to back from idle, the first output is visible 6 edges after the edge that accepts the first pixel.
- R9: A window with |d1−d2| equal to the threshold is in the smooth class. The same window with a threshold one lower is in the concave or convex class.
- R10: Gaps in the input stream stall output issue but change no output value and no output order.
- R11: A one-pixel line produces no output. A two-pixel line produces the outputs of the single interval between its two pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_data | input | 8 | Input pixel |
| in_last | input | 1 | Marks the last pixel of a line |
| in_ready | output | 1 | Block takes the pixel this cycle when in_valid is high |
| step | input | 8 | Phase increment per output, 1..255 (128 gives 2x, 171 gives about 1.5x) |
| thresh | input | 9 | Largest slope mismatch still treated as smooth (typical value 4) |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 8 | Interpolated pixel |

## Verification
A wrong phase register or a missed wrap shows at the ports within one line, as a wrong output count or a value taken at the wrong position. The scoreboard reports it on the first affected pixel. A wrong curve class or weight only shows where the slopes of a window disagree by more than the threshold, so the bench feeds edges and threshold boundary windows. Those errors appear 4 edges after the affected issue. A fault in end-of-line replication changes only the first and last intervals of a line, and a fault in the stall logic only shows when the input has gaps. Both are therefore exercised with distinct end pixels and with stuttered input.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int PIX_W   = 8;
  localparam int PH_W    = 8;
  localparam int NTAP    = 4;
  localparam int WF      = 6;               // weight fraction bits (Q2.6)
  localparam int CF      = 3 * PH_W;        // kernel coefficient fraction bits
  localparam int DIF_W   = PIX_W + 1;
  localparam int THR_W   = PIX_W + 1;
  localparam int CO_W    = CF + 2;
  localparam int ACC_W   = CF + WF + PIX_W + 8;
  localparam int RSH     = CF + WF;
  localparam int NPH     = 2 ** PH_W;
  localparam int PIX_MAX = 2 ** PIX_W - 1;

  typedef logic [PIX_W-1:0]            pix_t;
  typedef logic [PH_W-1:0]             ph_t;
  typedef logic [THR_W-1:0]            thr_t;
  typedef logic signed [DIF_W-1:0]     dif_t;
  typedef logic signed [CO_W-1:0]      coef_t;
  typedef logic signed [WF+1:0]        wgt_t;
  typedef logic signed [ACC_W-1:0]     acc_t;
  typedef logic [NTAP-1:0][PIX_W-1:0]  win_t;   // [0] oldest neighbour .. [3] newest

  typedef enum logic [1:0] {
    SEG_SMOOTH  = 2'd0,
    SEG_CONCAVE = 2'd1,
    SEG_CONVEX  = 2'd2
  } seg_e;

  localparam wgt_t W_SMOOTH  = wgt_t'(-(2 ** (WF - 1)));
  localparam wgt_t W_CONCAVE = wgt_t'(-(3 * 2 ** (WF - 2)));
  localparam wgt_t W_CONVEX  = wgt_t'(-(2 ** (WF - 2)));
  localparam wgt_t W_UNIT    = wgt_t'(2 ** WF);

  function automatic dif_t sub_pix(pix_t a, pix_t b);
    return signed'({1'b0, a}) - signed'({1'b0, b});
  endfunction

  // Kernel polynomials, scaled by 2^CF, exact for every phase.
  function automatic coef_t coef_a(ph_t ph);
    acc_t s, u;
    s = acc_t'(ph);
    u = acc_t'(NPH);
    return coef_t'(s * s * s - acc_t'(2) * s * s * u + s * u * u);
  endfunction

  function automatic coef_t coef_b(ph_t ph);
    acc_t s, u;
    s = acc_t'(ph);
    u = acc_t'(NPH);
    return coef_t'(s * s * s - s * s * u);
  endfunction

  function automatic coef_t coef_c(ph_t ph);
    acc_t s, u;
    s = acc_t'(ph);
    u = acc_t'(NPH);
    return coef_t'(acc_t'(2) * s * s * s - acc_t'(3) * s * s * u);
  endfunction

  function automatic seg_e classify(win_t w, thr_t thr);
    dif_t d1, d2;
    logic signed [DIF_W:0] e, mag;
    d1  = sub_pix(w[2], w[0]);
    d2  = sub_pix(w[3], w[1]);
    e   = {d1[DIF_W-1], d1} - {d2[DIF_W-1], d2};
    mag = e[DIF_W] ? -e : e;
    if (mag <= signed'({1'b0, thr})) return SEG_SMOOTH;
    if (!e[DIF_W]) return SEG_CONCAVE;
    return SEG_CONVEX;
  endfunction

  function automatic wgt_t seg_weight(seg_e seg);
    case (seg)
      SEG_CONCAVE: return W_CONCAVE;
      SEG_CONVEX:  return W_CONVEX;
      default:     return W_SMOOTH;
    endcase
  endfunction

  function automatic acc_t term(dif_t d, coef_t c);
    return acc_t'(d) * acc_t'(c);
  endfunction

  function automatic acc_t blend(wgt_t w, acc_t ta, acc_t tb, acc_t tc);
    return acc_t'(w) * (ta + tb) + acc_t'(W_UNIT) * tc;
  endfunction

  function automatic pix_t round_clamp(acc_t sum, pix_t base);
    acc_t y;
    y = ((sum + (acc_t'(1) <<< (RSH - 1))) >>> RSH) + acc_t'(base);
    if (y < 0) return '0;
    if (y > acc_t'(PIX_MAX)) return pix_t'(PIX_MAX);
    return pix_t'(y);
  endfunction
endpackage

// File: rtl/acs_window.sv
module acs_window
  import acs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  pix_t in_data,
  input  logic in_last,
  output logic in_ready,
  input  ph_t  step,
  output logic fire,
  output logic accept,
  output logic wrap,
  output win_t win,
  output ph_t  ph
);
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RUN} st_e;

  st_e         st;
  logic        fill, tail, padded, shift;
  pix_t        shift_in;
  logic [PH_W:0] ph_sum;

  assign ph_sum = {1'b0, ph} + {1'b0, step};
  assign wrap   = ph_sum[PH_W];
  assign accept = in_valid && in_ready;

  always_comb begin
    in_ready = 1'b0;
    fire     = 1'b0;
    unique case (st)
      ST_IDLE: in_ready = 1'b1;
      ST_FILL: in_ready = !tail;
      ST_RUN: begin
        in_ready = wrap && !tail;
        fire     = !wrap || tail || in_valid;
      end
      default: ;
    endcase
  end

  always_comb begin
    shift    = 1'b0;
    shift_in = win[NTAP-1];
    if (st == ST_FILL)     shift = tail ? !padded : in_valid;
    else if (st == ST_RUN) shift = fire && wrap && !(tail && padded);
    if (accept && st != ST_IDLE) shift_in = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      fill   <= 1'b0;
      tail   <= 1'b0;
      padded <= 1'b0;
      ph     <= '0;
      win    <= '0;
    end else if (st == ST_IDLE) begin
      if (accept) begin
        win    <= {NTAP{in_data}};
        fill   <= 1'b0;
        tail   <= in_last;
        padded <= 1'b0;
        ph     <= '0;
        st     <= ST_FILL;
      end
    end else begin
      if (shift) begin
        for (int i = 0; i < NTAP - 1; i++) win[i] <= win[i+1];
        win[NTAP-1] <= shift_in;
        if (accept) tail   <= in_last;
        if (tail)   padded <= 1'b1;
      end
      if (fire) ph <= ph_sum[PH_W-1:0];
      if (st == ST_FILL) begin
        if (tail && padded) st <= ST_IDLE;
        else if (shift) begin
          fill <= 1'b1;
          if (fill) st <= ST_RUN;
        end
      end else if (fire && wrap && tail && padded) begin
        st <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/acs_classify.sv
module acs_classify
  import acs_pkg::*;
(
  input  win_t win,
  input  thr_t thresh,
  output wgt_t wgt
);
  seg_e seg;
  assign seg = classify(win, thresh);
  assign wgt = seg_weight(seg);
endmodule

// File: rtl/acs_datapath.sv
module acs_datapath
  import acs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  win_t win,
  input  ph_t  ph,
  input  wgt_t wgt,
  output logic out_valid,
  output pix_t out_data
);
  coef_t lut_a [NPH];
  coef_t lut_b [NPH];
  coef_t lut_c [NPH];

  for (genvar i = 0; i < NPH; i++) begin : g_lut
    assign lut_a[i] = coef_a(ph_t'(i));
    assign lut_b[i] = coef_b(ph_t'(i));
    assign lut_c[i] = coef_c(ph_t'(i));
  end

  logic  v1, v2, v3;
  dif_t  da, db, dc;
  coef_t ca, cb, cc;
  wgt_t  w1, w2;
  pix_t  b1, b2, b3;
  acc_t  ta, tb, tc, sum3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; out_valid <= 1'b0;
      da <= '0; db <= '0; dc <= '0;
      ca <= '0; cb <= '0; cc <= '0;
      w1 <= '0; w2 <= '0;
      b1 <= '0; b2 <= '0; b3 <= '0;
      ta <= '0; tb <= '0; tc <= '0; sum3 <= '0;
      out_data <= '0;
    end else begin
      // stage 1: differences, weight, kernel lookup
      v1 <= issue;
      da <= sub_pix(win[0], win[2]);
      db <= sub_pix(win[1], win[3]);
      dc <= sub_pix(win[1], win[2]);
      ca <= lut_a[ph];
      cb <= lut_b[ph];
      cc <= lut_c[ph];
      w1 <= wgt;
      b1 <= win[1];
      // stage 2: difference times kernel
      v2 <= v1;
      ta <= term(da, ca);
      tb <= term(db, cb);
      tc <= term(dc, cc);
      w2 <= w1;
      b2 <= b1;
      // stage 3: weighted sum
      v3   <= v2;
      sum3 <= blend(w2, ta, tb, tc);
      b3   <= b2;
      // stage 4: round, add centre pixel, clamp
      out_valid <= v3;
      out_data  <= round_clamp(sum3, b3);
    end
  end
endmodule

// File: rtl/acs_scaler.sv
module acs_scaler
  import acs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic [PH_W-1:0]  step,
  input  logic [THR_W-1:0] thresh,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data
);
  logic fire, accept, wrap;
  win_t win;
  ph_t  ph;
  wgt_t wgt;

  acs_window u_win (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .step(step), .fire(fire), .accept(accept), .wrap(wrap), .win(win), .ph(ph)
  );

  acs_classify u_cls (
    .win(win), .thresh(thresh), .wgt(wgt)
  );

  acs_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .issue(fire), .win(win), .ph(ph), .wgt(wgt),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/acs_scaler_chk.sv
module acs_scaler_chk
  import acs_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input pix_t in_data,
  input ph_t  step,
  input logic fire,
  input logic accept,
  input logic wrap,
  input ph_t  ph,
  input win_t win,
  input logic out_valid
);
  AST_ISSUE_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(fire, 4)); // R8

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ph == ph_t'($past(ph) + $past(step))); // R3

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !accept) |=> $stable(ph)); // R3

  AST_NO_MIDSTEP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wrap) |-> !in_ready); // R4

  AST_TAKE_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && accept) |=> (win[NTAP-1] == $past(in_data)) && (win[NTAP-2] == $past(win[NTAP-1]))); // R4
endmodule

bind acs_scaler acs_scaler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .in_data(in_data), .step(step),
  .fire(fire), .accept(accept), .wrap(wrap), .ph(ph), .win(win), .out_valid(out_valid)
);

// File: tb/tb_acs_scaler.sv
module tb_acs_scaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [7:0] step = 8'd128;
  logic [8:0] thresh = 9'd4;
  logic       out_valid;
  logic [7:0] out_data;

  acs_scaler dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .step(step), .thresh(thresh), .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;  // 50 MHz

  int     n_chk = 0;
  int     n_err = 0;
  int     n_out = 0;
  longint cyc = 0;
  longint first_out = -1;
  int     exp_q[$];
  string  tag_q[$];
  longint acc_at[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference: restated from the requirements in factored form.
  function automatic int ref_pix(int p0, int p1, int p2, int p3, int s, int thr);
    longint a, b, c, sum, w, r;
    int e;
    e = (p2 - p0) - (p3 - p1);
    if (e <= thr && e >= -thr) w = -32;
    else if (e > 0)            w = -48;
    else                       w = -16;
    a = longint'(s) * (s - 256) * (s - 256);
    b = longint'(s) * s * (s - 256);
    c = longint'(s) * s * (2 * s - 768);
    sum = w * ((p0 - p2) * a + (p1 - p3) * b) + 64 * (p1 - p2) * c;
    r = p1 + ((sum + (longint'(1) <<< 29)) >>> 30);
    if (r < 0)   r = 0;
    if (r > 255) r = 255;
    return int'(r);
  endfunction

  task automatic push_line(int x[$], int stp, int thr, string tag);
    int n;
    n = x.size();
    for (longint pos = 0; (pos >>> 8) < n - 1; pos += stp) begin
      int k, s, i0, i3;
      k  = int'(pos >>> 8);
      s  = int'(pos & 255);
      i0 = (k > 0) ? k - 1 : 0;
      i3 = (k + 2 < n) ? k + 2 : n - 1;
      exp_q.push_back(ref_pix(x[i0], x[k], x[k+1], x[i3], s, thr));
      tag_q.push_back(tag);
    end
  endtask

  task automatic send_line(int x[$], int gap);
    acc_at.delete();
    for (int i = 0; i < x.size(); i++) begin
      in_valid = 1'b1;
      in_data  = 8'(x[i]);
      in_last  = (i == x.size() - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      acc_at.push_back(cyc);
      in_valid = 1'b0;
      in_last  = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (exp_q.size() > 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    for (int i = 0; i < 10; i++) @(negedge clk);
    check(exp_q.size() == 0, "R3", "outputs still missing", exp_q.size(), 0);
  endtask

  task automatic run_line(int x[$], int stp, int thr, int gap, string tag);
    step   = 8'(stp);
    thresh = 9'(thr);
    push_line(x, stp, thr, tag);
    send_line(x, gap);
    drain();
  endtask

  // Monitor: compare each output against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_out++;
      if (first_out < 0) first_out = cyc;
      if (exp_q.size() == 0) check(1'b0, "R3", "unexpected output", out_data, -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == 8'(e), t, "pixel", out_data, e);
      end
    end
  end

  task automatic run_tests();
    int x[$];
    int base;
    // R1: reset state
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R2 ramp at 2x, R3 count, R8 first-output latency
    x = {10, 20, 30, 40, 50, 60};
    base = n_out;
    first_out = -1;
    run_line(x, 128, 4, 0, "R2");
    check(n_out - base == 10, "R3", "output count 6 px at 2x", n_out - base, 10);
    check(first_out == acc_at[0] + 6, "R8", "first output edge", first_out, acc_at[0] + 6);

    // R5 concave/convex edges at about 1.5x
    x = {0, 0, 0, 255, 255, 255, 0, 0, 128, 40};
    run_line(x, 171, 4, 0, "R5");
    // R7 overshoot and undershoot clamp
    x = {255, 0, 0, 255, 0, 255, 255, 0};
    run_line(x, 128, 4, 0, "R7");
    // R6 distinct end pixels exercise replication
    x = {200, 10, 60, 250};
    run_line(x, 100, 4, 0, "R6");
    // R9 threshold boundary: |d1-d2| = 10
    x = {100, 100, 110, 100, 100};
    run_line(x, 64, 10, 0, "R9");
    run_line(x, 64, 9, 0, "R9");
    // R4 accept spacing at 4x with input always valid
    x = {30, 90, 20, 160, 70, 240, 5};
    run_line(x, 64, 4, 0, "R4");
    check(acc_at[3] - acc_at[2] == 4, "R4", "accept spacing 2->3", acc_at[3] - acc_at[2], 4);
    check(acc_at[4] - acc_at[3] == 4, "R4", "accept spacing 3->4", acc_at[4] - acc_at[3], 4);
    check(acc_at[1] - acc_at[0] == 1, "R4", "priming accept spacing", acc_at[1] - acc_at[0], 1);
    // R10 same line with gaps
    run_line(x, 64, 4, 3, "R10");
    run_line(x, 171, 4, 7, "R10");
    // R11 one- and two-pixel lines
    base = n_out;
    x = {77};
    run_line(x, 128, 4, 0, "R11");
    check(n_out == base, "R11", "one-pixel line outputs", n_out - base, 0);
    base = n_out;
    x = {0, 200};
    run_line(x, 128, 4, 0, "R11");
    check(n_out - base == 2, "R11", "two-pixel line outputs", n_out - base, 2);
    // R3 near-maximal step
    x = {5, 250, 5, 250};
    base = n_out;
    run_line(x, 255, 4, 0, "R3");
    check(n_out - base == 4, "R3", "output count step 255", n_out - base, 4);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule